// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is a clock-synchronous SMBus target that owns an eight-entry byte-wide configuration file. The SCL and SDA pins arrive as raw levels. Each one passes through a two-flop synchroniser and a short stability filter. SDA is driven only through an open-drain enable. The host reaches the file with indexed block transfers. A write carries a start index, a byte count and then the data. A read first sets the index, then issues a repeated start and a read address, and the target answers with the programmed count byte followed by data.

The 7-bit target address is chosen by a three-level strap. The strap is captured once, on the first rising edge of the power-good input. Four writable entries drive control outputs toward downstream logic, together with the five-bit read count. The read-only entries hold an identity and a reserved pattern. The index advances after every data byte and wraps modulo eight. The target takes part in transfers only while its system clock runs, and its filters assume an SCL rate of at most 400 kHz.

Top module: `smb_cfg_target`

## Requirements
- R1: The target address is 0x6B when `strap_lvl` is 2'b00 (low), 0x6C when it is 2'b01 (mid), and 0x6D when it is 2'b10 or 2'b11 (high). It is captured on the first rising edge of `pwr_good` after reset. Later strap changes are ignored. Before that edge, no address is acknowledged.
- R2: When a byte that follows a start does not carry the target address, the target leaves SDA released in the acknowledge slot. It then ignores all bus traffic until the next start.
- R3: In a block write, the address (R/W bit 0 = write), the index byte (only bits [2:0] used), the count byte and each data byte are acknowledged. Data lands at index N, N+1, and so on, with the index wrapping from 7 to 0.
- R4: A data byte beyond the count given in the write is not acknowledged and is not stored. The target then stays idle until the next start.
- R5: In a read (address with R/W bit 1 after a repeated start), the first byte sent is {3'b000, read count}. Data then follows from the current index, and the index increments on each host ACK. After a host NACK, SDA is released and the target goes idle.
- R6: Reset values: index 0 = 0xFF, index 1 = 0x06, index 2 = 0xFF, index 3 = 0xC7, read count (index 7 bits [4:0]) = 8.
- R7: Index 0 bits 5 and 1 always read 1, and writes to them have no effect. Index 7 bits [7:5] always read 0.
- R8: Index 4 reads 0xFF, index 5 reads 0x01 and index 6 reads 0x46. Writes to these three are acknowledged and change nothing.
- R9: `out_enable`, `pll_ctrl`, `slew_ctrl`, `freq_ctrl` and `read_count` show the contents of indices 0, 1, 2, 3 and 7[4:0] once the write transfer ends.
- R10: `sda_oe` changes only while SCL is low. It is asserted only in an acknowledge slot driven by the target or in a data bit it transmits.
- R11: A stop condition that arrives partway through a byte discards that byte. The next start begins a fresh transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good; its first rising edge captures the strap |
| strap_lvl | input | 2 | Three-level address strap: 00 low, 01 mid, 1x high |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level (wired bus) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| out_enable | output | 8 | Index 0: per-output enable bits |
| pll_ctrl | output | 8 | Index 1: loop mode and amplitude control |
| slew_ctrl | output | 8 | Index 2: per-output slew select |
| freq_ctrl | output | 8 | Index 3: frequency select control |
| read_count | output | 5 | Index 7 [4:0]: bytes returned by a read |

## Verification
The states hardest to reach from the ports are the edges of a transfer. One is a data byte past the declared count. Another is a stop that lands between bit four and bit five of a byte. A third is a read that runs through the read-only area and wraps past index 7. The bench drives SDA and SCL bit by bit through host tasks. These can declare a short count and then send one byte more, or cut a byte off with a stop after a chosen number of bits, so each of these cases arises on purpose. The results are then read back through the control outputs and through a later block read.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int REG_IDX_W = 3;
  localparam int CNT_W     = 5;
  localparam logic [7:0] ENABLE_MASK = 8'hDD;
  localparam logic [7:0] RSVD_VALUE  = 8'hFF;
  localparam logic [7:0] REV_VALUE   = 8'h01;
  localparam logic [7:0] DEVID_VALUE = 8'h46;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK_OUT, PH_TX, PH_ACK_IN
  } phase_t;

  typedef enum logic [2:0] {
    SP_ADDR, SP_INDEX, SP_COUNT, SP_WDATA, SP_RDATA
  } step_t;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == clean) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        clean <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_addr_strap.sv
module smb_addr_strap #(
  parameter logic [6:0] ADDR_LO  = 7'h6B,
  parameter logic [6:0] ADDR_MID = 7'h6C,
  parameter logic [6:0] ADDR_HI  = 7'h6D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic [1:0] strap_lvl,
  output logic [6:0] my_addr,
  output logic       addr_ok
);
  logic pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q    <= 1'b0;
      addr_ok <= 1'b0;
      my_addr <= ADDR_LO;
    end else begin
      pg_q <= pwr_good;
      if (pwr_good && !pg_q && !addr_ok) begin
        addr_ok <= 1'b1;
        case (strap_lvl)
          2'b00:   my_addr <= ADDR_LO;
          2'b01:   my_addr <= ADDR_MID;
          default: my_addr <= ADDR_HI;
        endcase
      end
    end
  end

  assert_addr_kept_R1: assert property (@(posedge clk) disable iff (rst)
    addr_ok |=> addr_ok);
  assert_addr_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    addr_ok |=> $stable(my_addr));
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0]       RST_ENABLE = 8'hFF,
  parameter logic [7:0]       RST_PLL    = 8'h06,
  parameter logic [7:0]       RST_SLEW   = 8'hFF,
  parameter logic [7:0]       RST_FREQ   = 8'hC7,
  parameter logic [CNT_W-1:0] RST_COUNT  = 5'd8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [7:0]           rd_data,
  output logic [7:0]           out_enable,
  output logic [7:0]           pll_ctrl,
  output logic [7:0]           slew_ctrl,
  output logic [7:0]           freq_ctrl,
  output logic [CNT_W-1:0]     read_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_enable <= RST_ENABLE | ~ENABLE_MASK;
      pll_ctrl   <= RST_PLL;
      slew_ctrl  <= RST_SLEW;
      freq_ctrl  <= RST_FREQ;
      read_count <= RST_COUNT;
    end else if (wr_en) begin
      case (wr_idx)
        3'd0:    out_enable <= (wr_data & ENABLE_MASK) | ~ENABLE_MASK;
        3'd1:    pll_ctrl   <= wr_data;
        3'd2:    slew_ctrl  <= wr_data;
        3'd3:    freq_ctrl  <= wr_data;
        3'd7:    read_count <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      3'd0:    rd_data = out_enable;
      3'd1:    rd_data = pll_ctrl;
      3'd2:    rd_data = slew_ctrl;
      3'd3:    rd_data = freq_ctrl;
      3'd4:    rd_data = RSVD_VALUE;
      3'd5:    rd_data = REV_VALUE;
      3'd6:    rd_data = DEVID_VALUE;
      default: rd_data = {{(8-CNT_W){1'b0}}, read_count};
    endcase
  end

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({out_enable, pll_ctrl, slew_ctrl, freq_ctrl, read_count}));
  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == 3'd4 || wr_idx == 3'd5 || wr_idx == 3'd6))
      |=> $stable({out_enable, pll_ctrl, slew_ctrl, freq_ctrl, read_count}));
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] ADDR_LO  = 7'h6B,
  parameter logic [6:0] ADDR_MID = 7'h6C,
  parameter logic [6:0] ADDR_HI  = 7'h6D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic [1:0]       strap_lvl,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [7:0]       out_enable,
  output logic [7:0]       pll_ctrl,
  output logic [7:0]       slew_ctrl,
  output logic [7:0]       freq_ctrl,
  output logic [CNT_W-1:0] read_count
);
  logic [1:0] raw_v, clean_v;
  logic       scl_f, sda_f, scl_q, sda_q;
  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .raw(raw_v[g]), .clean(clean_v[g]));
  end
  assign scl_f = clean_v[0];
  assign sda_f = clean_v[1];

  logic [6:0] my_addr;
  logic       addr_ok;
  smb_addr_strap #(.ADDR_LO(ADDR_LO), .ADDR_MID(ADDR_MID), .ADDR_HI(ADDR_HI)) u_strap (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_lvl(strap_lvl),
    .my_addr(my_addr), .addr_ok(addr_ok));

  phase_t               phase;
  step_t                step;
  logic [3:0]           bit_cnt;
  logic [7:0]           shreg, wr_left, rd_data, rx_byte, count_byte;
  logic [REG_IDX_W-1:0] idx, reg_widx;
  logic [7:0]           reg_wdata;
  logic                 reg_we, is_read, ack_on, host_ack;

  smb_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_idx(reg_widx), .wr_data(reg_wdata),
    .rd_idx(idx), .rd_data(rd_data), .out_enable(out_enable), .pll_ctrl(pll_ctrl),
    .slew_ctrl(slew_ctrl), .freq_ctrl(freq_ctrl), .read_count(read_count));

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign rx_byte    = {shreg[6:0], sda_f};
  assign count_byte = {{(8-CNT_W){1'b0}}, read_count};

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      phase <= PH_IDLE; step <= SP_ADDR;
      bit_cnt <= '0; shreg <= '0; wr_left <= '0; idx <= '0;
      reg_we <= 1'b0; reg_widx <= '0; reg_wdata <= '0;
      is_read <= 1'b0; ack_on <= 1'b0; host_ack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q  <= scl_f;
      sda_q  <= sda_f;
      reg_we <= 1'b0;
      if (stop_ev) begin
        phase <= PH_IDLE; sda_oe <= 1'b0;
      end else if (start_ev) begin
        phase <= PH_RX; step <= SP_ADDR; bit_cnt <= '0;
        sda_oe <= 1'b0; ack_on <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 4'd7) begin
              bit_cnt <= '0;
              ack_on  <= 1'b0;
              phase   <= PH_ACK_OUT;
              case (step)
                SP_ADDR: begin
                  is_read <= rx_byte[0];
                  if (!(addr_ok && rx_byte[7:1] == my_addr)) phase <= PH_IDLE;
                end
                SP_INDEX: idx <= rx_byte[REG_IDX_W-1:0];
                SP_COUNT: wr_left <= rx_byte;
                SP_WDATA: begin
                  if (wr_left != 8'd0) begin
                    reg_we    <= 1'b1;
                    reg_widx  <= idx;
                    reg_wdata <= rx_byte;
                    idx       <= idx + 1'b1;
                    wr_left   <= wr_left - 1'b1;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                default: phase <= PH_IDLE;
              endcase
            end
          end
          PH_ACK_OUT: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1;
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              phase  <= PH_RX;
              case (step)
                SP_ADDR: begin
                  if (is_read) begin
                    phase   <= PH_TX;
                    step    <= SP_RDATA;
                    shreg   <= count_byte;
                    sda_oe  <= ~count_byte[7];
                    bit_cnt <= '0;
                  end else begin
                    step <= SP_INDEX;
                  end
                end
                SP_INDEX: step <= SP_COUNT;
                SP_COUNT: step <= SP_WDATA;
                default:  ;
              endcase
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                phase   <= PH_ACK_IN;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          PH_ACK_IN: begin
            if (scl_rise) begin
              host_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                idx    <= idx + 1'b1;
                phase  <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_f && scl_q) |-> $stable(sda_oe));
  assert_oe_in_slot_R10: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (phase == PH_ACK_OUT || phase == PH_TX));
endmodule

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, pwr_good;
  logic [1:0] strap_lvl;
  logic       scl_drv, sda_drv;
  logic       sda_oe;
  logic [7:0] out_enable, pll_ctrl, slew_ctrl, freq_ctrl;
  logic [4:0] read_count;
  wire        sda_bus = sda_drv & ~sda_oe;

  smb_cfg_target dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_lvl(strap_lvl),
    .scl_in(scl_drv), .sda_in(sda_bus), .sda_oe(sda_oe),
    .out_enable(out_enable), .pll_ctrl(pll_ctrl), .slew_ctrl(slew_ctrl),
    .freq_ctrl(freq_ctrl), .read_count(read_count));

  int checks = 0, fails = 0, viol = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  // R10 monitor: sda_oe must not move while SCL is high
  always @(negedge clk) begin
    #1;
    if (!rst && (sda_oe !== oe_prev) && scl_drv && scl_prev) viol++;
    oe_prev  = sda_oe;
    scl_prev = scl_drv;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (20) @(negedge clk);
  endtask

  task automatic h_start();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b0; qwait();
  endtask
  task automatic h_rstart();
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b0; qwait();
  endtask
  task automatic h_stop();
    sda_drv = 1'b0; qwait(); scl_drv = 1'b1; qwait(); sda_drv = 1'b1; qwait(); qwait();
  endtask
  task automatic bit_w(input logic b);
    sda_drv = b; qwait(); scl_drv = 1'b1; qwait(); qwait(); scl_drv = 1'b0; qwait();
  endtask
  task automatic bit_r(output logic b);
    sda_drv = 1'b1; qwait(); scl_drv = 1'b1; qwait(); b = sda_bus; qwait();
    scl_drv = 1'b0; qwait();
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b);
    ack = ~b;
  endtask
  task automatic rd_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(~give_ack);
  endtask

  // acks: bit0 address, bit1 index, bit2 count, bit3+k data byte k
  task automatic block_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                             input int n, input logic [63:0] dat, output logic [15:0] acks);
    logic ak;
    acks = '0;
    h_start();
    wr_byte({a, 1'b0}, ak); acks[0] = ak;
    wr_byte(idx, ak);       acks[1] = ak;
    wr_byte(cnt, ak);       acks[2] = ak;
    for (int k = 0; k < n; k++) begin
      wr_byte(dat[8*k +: 8], ak); acks[3+k] = ak;
    end
    h_stop();
  endtask

  task automatic block_read(input logic [6:0] a, input logic [7:0] idx, input int n,
                            output logic [7:0] cntb, output logic [63:0] dat, output logic aok);
    logic ak, ak2;
    logic [7:0] d;
    dat = '0;
    h_start();
    wr_byte({a, 1'b0}, ak);
    wr_byte(idx, ak2);
    h_rstart();
    wr_byte({a, 1'b1}, ak2);
    aok = ak & ak2;
    rd_byte(cntb, 1'b1);
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k != n - 1);
      dat[8*k +: 8] = d;
    end
    h_stop();
  endtask

  task automatic t_reset();
    chk("R6 enable reset", out_enable, 8'hFF);
    chk("R6 pll reset", pll_ctrl, 8'h06);
    chk("R6 slew reset", slew_ctrl, 8'hFF);
    chk("R6 freq reset", freq_ctrl, 8'hC7);
    chk("R6 count reset", read_count, 5'd8);
    chk("R10 sda idle", sda_oe, 1'b0);
  endtask

  task automatic t_before_power_good();
    logic [15:0] acks;
    block_write(7'h6B, 8'd1, 8'd1, 1, 64'h5A, acks);
    chk("R1 no ack before power-good", acks[0], 1'b0);
    chk("R1 no write before power-good", pll_ctrl, 8'h06);
  endtask

  task automatic t_strap_latch();
    logic [15:0] acks;
    strap_lvl = 2'b00;
    pwr_good = 1'b1;
    repeat (10) @(negedge clk);
    strap_lvl = 2'b10;
    repeat (10) @(negedge clk);
    block_write(7'h6D, 8'd1, 8'd1, 1, 64'h77, acks);
    chk("R1 late strap ignored", acks[0], 1'b0);
    block_write(7'h6C, 8'd1, 8'd1, 1, 64'h77, acks);
    chk("R2 mismatch nack", acks[0], 1'b0);
    chk("R2 index byte ignored", acks[1], 1'b0);
    chk("R2 no write", pll_ctrl, 8'h06);
  endtask

  task automatic t_write();
    logic [15:0] acks;
    block_write(7'h6B, 8'd1, 8'd3, 3, 64'h81_3C_5A, acks);
    chk("R3 write acks", acks[5:0], 6'h3F);
    chk("R9 pll out", pll_ctrl, 8'h5A);
    chk("R9 slew out", slew_ctrl, 8'h3C);
    chk("R3 freq out", freq_ctrl, 8'h81);
  endtask

  task automatic t_wrap();
    logic [15:0] acks;
    block_write(7'h6B, 8'd7, 8'd2, 2, 64'h00_0C, acks);
    chk("R3 wrap acks", acks[4:0], 5'h1F);
    chk("R9 count out", read_count, 5'h0C);
    chk("R7 enable fixed bits", out_enable, 8'h22);
  endtask

  task automatic t_budget();
    logic [15:0] acks;
    block_write(7'h6B, 8'd2, 8'd1, 2, 64'h99_11, acks);
    chk("R4 in-budget ack", acks[3:0], 4'hF);
    chk("R4 extra byte nack", acks[4], 1'b0);
    chk("R4 in-budget written", slew_ctrl, 8'h11);
    chk("R4 extra not written", freq_ctrl, 8'h81);
  endtask

  task automatic t_read();
    logic [7:0]  cb;
    logic [63:0] d;
    logic        aok;
    block_read(7'h6B, 8'd4, 5, cb, d, aok);
    chk("R5 read address ack", aok, 1'b1);
    chk("R5 count byte first", cb, 8'h0C);
    chk("R8 idx4", d[7:0], 8'hFF);
    chk("R8 idx5", d[15:8], 8'h01);
    chk("R8 idx6", d[23:16], 8'h46);
    chk("R7 idx7", d[31:24], 8'h0C);
    chk("R5 wrap to idx0", d[39:32], 8'h22);
    chk("R5 released after nack", sda_oe, 1'b0);
  endtask

  task automatic t_ro_write();
    logic [15:0] acks;
    logic [7:0]  cb;
    logic [63:0] d;
    logic        aok;
    block_write(7'h6B, 8'd4, 8'd4, 4, 64'hFF_00_00_00, acks);
    chk("R8 ro writes acked", acks[6:0], 7'h7F);
    chk("R7 count low bits", read_count, 5'h1F);
    block_read(7'h6B, 8'd4, 4, cb, d, aok);
    chk("R7 count byte top zero", cb, 8'h1F);
    chk("R8 ro unchanged", d[23:0], 24'h46_01_FF);
    chk("R7 idx7 top zero", d[31:24], 8'h1F);
  endtask

  task automatic t_abort();
    logic ak;
    logic [15:0] acks;
    h_start();
    wr_byte(8'hD6, ak);
    wr_byte(8'd3, ak);
    wr_byte(8'd2, ak);
    for (int i = 0; i < 4; i++) bit_w(1'b0);
    h_stop();
    chk("R11 partial byte dropped", freq_ctrl, 8'h81);
    block_write(7'h6B, 8'd3, 8'd1, 1, 64'h42, acks);
    chk("R11 fresh transfer acks", acks[3:0], 4'hF);
    chk("R11 fresh transfer writes", freq_ctrl, 8'h42);
  endtask

  initial begin
    rst = 1'b1; pwr_good = 1'b0; strap_lvl = 2'b00;
    scl_drv = 1'b1; sda_drv = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_before_power_good();
    t_strap_latch();
    t_write();
    t_wrap();
    t_budget();
    t_read();
    t_ro_write();
    t_abort();
    chk("R10 sda_oe steady while SCL high", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule